// File: doc/BRIEF.md
# PHY Packet Receive Controller

This block sits on the link side of a serial-bus node and handles PHY packets after they have been pulled off the wire. Each packet arrives as two quadlets on `rx_data` with `rx_valid` high: a header quadlet, then a check quadlet. The block can optionally validate the packet. It then sorts the packet by its header bits into one of these classes: configuration, ping, link-on, remote access, remote command, or other. Each class has its own enable bit in a six-bit control register, and that bit decides whether hardware reacts to the class.

Hardware reactions are:
- loading the local gap count and root-holdoff flag from a configuration packet;
- pulsing a self-ID transmit request for a ping;
- pulsing a remote reply or remote confirmation request;
- setting the link-active flag that gates link-layer traffic.

Every packet that passes validation is also handed up on `out_valid`/`out_data`, whether or not hardware reacted to it. On a bus reset the block drops any half-received packet and suppresses pending requests. It clears the link-active flag and, if enabled, emits a synthetic bus-reset word on the output path.

The sequencer has four states:
- `ST_IDLE`: no packet in progress.
- `ST_WAIT_CHECK`: the header quadlet is held, waiting for the check quadlet.
- `ST_ACT`: one cycle in which the packet is judged, forwarded and acted on.
- `ST_BR_EMIT`: one cycle in which the synthetic bus-reset word is presented.

Transitions:
- `ST_IDLE` goes to `ST_WAIT_CHECK` on a valid quadlet.
- `ST_WAIT_CHECK` goes to `ST_ACT` on a valid quadlet.
- `ST_ACT` and `ST_BR_EMIT` go to `ST_WAIT_CHECK` if a valid quadlet arrives in that cycle, otherwise to `ST_IDLE`.
- From any state, `bus_reset` forces `ST_BR_EMIT` when the bus-reset-word enable is set, otherwise `ST_IDLE`.

Top module: `phy_rx_ctrl`

## Requirements
- R1: After reset, `ctrl_q` is 6'b011100, `gap_count` is 6'h3F, and `rhb`, `link_active`, `out_valid` and all request outputs are 0. The `ctrl_q` bits are: bit0 auto-configure, bit1 link gating, bit2 auto-ping, bit3 auto-remote, bit4 bus-reset word, bit5 check.
- R2: When `ctrl_q[5]` is 1, a packet whose check quadlet is not the bitwise inverse of its header is discarded: no `out_valid` and no request. When `ctrl_q[5]` is 0, the check quadlet is ignored.
- R3: A packet that passes is forwarded with `out_valid` high for one cycle and `out_data` equal to its header quadlet. This happens in the cycle after its check quadlet is accepted, which is two cycles after the header quadlet.
- R4: Header bits [31:30]=00 with R (bit 23) or T (bit 22) set mark a configuration packet. With `ctrl_q[0]` set, T=1 loads `gap_count` from bits [21:16]. R=1 sets `rhb` to 1 exactly when the root ID in bits [29:24] equals `node_id`. With `ctrl_q[0]` clear, both are left unchanged.
- R5: Header bits [31:30]=00 with R=T=0 mark an extended packet whose sub-type is in bits [21:18]. A sub-type 0 (ping) whose ID in bits [29:24] equals `node_id`, with `ctrl_q[2]` set, pulses `req_self_id` in the forwarding cycle. Any other ID, or `ctrl_q[2]` clear, gives no pulse.
- R6: With `ctrl_q[3]` set, sub-type 1 pulses `req_remote_reply` and sub-type 8 pulses `req_remote_confirm` in the forwarding cycle. With `ctrl_q[3]` clear, neither request is pulsed.
- R7: A header with bits [31:30]=01 whose ID in bits [29:24] equals `node_id` is a link-on packet and sets `link_active`. `link_ok` is `host_link_en` AND (NOT `ctrl_q[1]` OR `link_active`).
- R8: A `bus_reset` cycle clears `link_active`, discards a partly received packet, and suppresses that cycle's forwarding and requests. If `ctrl_q[4]` is set, the next cycle shows `out_valid`=1, `out_is_br`=1 and `out_data`=32'hE0000000. If `ctrl_q[4]` is clear, no output is produced.
- R9: Self-ID headers (bits [31:30]=10) and other extended sub-types are forwarded and change no node state.
- R10: A cycle with `cfg_we` high loads `cfg_wdata` into `ctrl_q`, and the new value is visible on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 6 | Control register write value |
| ctrl_q | output | 6 | Current control register |
| node_id | input | 6 | Local node physical ID |
| host_link_en | input | 1 | Host-side link enable |
| bus_reset | input | 1 | Bus reset indication, one cycle |
| rx_valid | input | 1 | Received quadlet valid |
| rx_data | input | 32 | Received quadlet |
| out_valid | output | 1 | Forwarded word valid |
| out_data | output | 32 | Forwarded header or bus-reset word |
| out_is_br | output | 1 | Forwarded word is the synthetic bus-reset word |
| gap_count | output | 6 | Local gap count |
| rhb | output | 1 | Root-holdoff flag |
| link_active | output | 1 | Link-on packet seen since last bus reset |
| link_ok | output | 1 | Link traffic allowed |
| req_self_id | output | 1 | Self-ID transmit request pulse |
| req_remote_reply | output | 1 | Remote reply transmit request pulse |
| req_remote_confirm | output | 1 | Remote confirmation transmit request pulse |

## Verification
The properties assume that quadlets on `rx_data` arrive in pairs, and that `bus_reset` is a single-cycle pulse that may land anywhere within a pair. They also assume that `cfg_we` is not raised in the same cycle as a packet's forwarding cycle. The stimulus writes the control register only while the sequencer is idle. It always sends two quadlets back to back, except in the one directed case that cuts a pair short with a bus reset. Bus resets are raised either alone or inside the action cycle.

// File: rtl/phy_rx_pkg.sv
package phy_rx_pkg;

    localparam int CTRL_W = 6;

    localparam int CB_AUTO_CFG  = 0;
    localparam int CB_LINK_GATE = 1;
    localparam int CB_AUTO_PING = 2;
    localparam int CB_AUTO_RMT  = 3;
    localparam int CB_BR_WORD   = 4;
    localparam int CB_CHECK     = 5;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 6'b011100;

    typedef enum logic [2:0] {
        PK_CONFIG,
        PK_PING,
        PK_LINKON,
        PK_RACCESS,
        PK_RCOMMAND,
        PK_OTHER
    } pkt_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_CHECK,
        ST_ACT,
        ST_BR_EMIT
    } rx_state_e;

endpackage

// File: rtl/phy_rx_ctrl_reg.sv
module phy_rx_ctrl_reg #(
    parameter int W = 6,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[b] <= RESET_VAL[b];
            end else if (we) begin
                q[b] <= wdata[b];
            end
        end
    end

endmodule

// File: rtl/phy_rx_decode.sv
module phy_rx_decode
    import phy_rx_pkg::*;
#(
    parameter int IDW  = 6,
    parameter int GAPW = 6
) (
    input  logic [2+IDW+2+GAPW-1:0] hdr,
    input  logic [IDW-1:0]          node_id,
    output pkt_class_e              cls,
    output logic                    cfg_r,
    output logic                    cfg_t,
    output logic [GAPW-1:0]         cfg_gap,
    output logic                    id_match
);

    localparam int HW      = 2 + IDW + 2 + GAPW;
    localparam int ID_LSB  = HW - 2 - IDW;
    localparam int R_BIT   = ID_LSB - 1;
    localparam int T_BIT   = ID_LSB - 2;
    localparam int SUB_LSB = T_BIT - 4;

    logic [1:0]     kind;
    logic [3:0]     sub_type;
    logic [IDW-1:0] pkt_id;

    assign kind     = hdr[HW-1 -: 2];
    assign pkt_id   = hdr[ID_LSB +: IDW];
    assign cfg_r    = hdr[R_BIT];
    assign cfg_t    = hdr[T_BIT];
    assign cfg_gap  = hdr[GAPW-1:0];
    assign sub_type = hdr[SUB_LSB +: 4];
    assign id_match = (pkt_id == node_id);

    always_comb begin
        cls = PK_OTHER;
        unique case (kind)
            2'b00: begin
                if (cfg_r || cfg_t) begin
                    cls = PK_CONFIG;
                end else begin
                    unique case (sub_type)
                        4'd0:    cls = id_match ? PK_PING : PK_OTHER;
                        4'd1:    cls = PK_RACCESS;
                        4'd8:    cls = PK_RCOMMAND;
                        default: cls = PK_OTHER;
                    endcase
                end
            end
            2'b01:   cls = id_match ? PK_LINKON : PK_OTHER;
            default: cls = PK_OTHER;
        endcase
    end

endmodule

// File: rtl/phy_rx_node_state.sv
module phy_rx_node_state #(
    parameter int GAPW = 6,
    parameter logic [GAPW-1:0] GAP_RESET = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_gap,
    input  logic [GAPW-1:0] new_gap,
    input  logic            upd_rhb,
    input  logic            new_rhb,
    input  logic            set_link,
    input  logic            clr_link,
    output logic [GAPW-1:0] gap_count,
    output logic            rhb,
    output logic            link_active
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_count <= GAP_RESET;
        end else if (upd_gap) begin
            gap_count <= new_gap;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rhb <= 1'b0;
        end else if (upd_rhb) begin
            rhb <= new_rhb;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_active <= 1'b0;
        end else if (clr_link) begin
            link_active <= 1'b0;
        end else if (set_link) begin
            link_active <= 1'b1;
        end
    end

endmodule

// File: rtl/phy_rx_ctrl.sv
module phy_rx_ctrl
    import phy_rx_pkg::*;
#(
    parameter int QW   = 32,
    parameter int IDW  = 6,
    parameter int GAPW = 6,
    parameter logic [QW-1:0] BR_WORD = 32'hE000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    input  logic [IDW-1:0]    node_id,
    input  logic              host_link_en,
    input  logic              bus_reset,
    input  logic              rx_valid,
    input  logic [QW-1:0]     rx_data,
    output logic              out_valid,
    output logic [QW-1:0]     out_data,
    output logic              out_is_br,
    output logic [GAPW-1:0]   gap_count,
    output logic              rhb,
    output logic              link_active,
    output logic              link_ok,
    output logic              req_self_id,
    output logic              req_remote_reply,
    output logic              req_remote_confirm
);

    localparam int HW = 2 + IDW + 2 + GAPW;

    rx_state_e        state, state_n;
    logic [QW-1:0]    hdr_q, chk_q;
    pkt_class_e       cls;
    logic             cfg_r, cfg_t, id_match;
    logic [GAPW-1:0]  cfg_gap;
    logic             act_cycle, pass, fire;
    logic             upd_gap, upd_rhb, set_link;

    phy_rx_ctrl_reg #(
        .W         (CTRL_W),
        .RESET_VAL (CTRL_RESET)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (ctrl_q)
    );

    phy_rx_decode #(
        .IDW  (IDW),
        .GAPW (GAPW)
    ) u_decode (
        .hdr      (hdr_q[QW-1 -: HW]),
        .node_id  (node_id),
        .cls      (cls),
        .cfg_r    (cfg_r),
        .cfg_t    (cfg_t),
        .cfg_gap  (cfg_gap),
        .id_match (id_match)
    );

    phy_rx_node_state #(
        .GAPW      (GAPW),
        .GAP_RESET ('1)
    ) u_node (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_gap     (upd_gap),
        .new_gap     (cfg_gap),
        .upd_rhb     (upd_rhb),
        .new_rhb     (id_match),
        .set_link    (set_link),
        .clr_link    (bus_reset),
        .gap_count   (gap_count),
        .rhb         (rhb),
        .link_active (link_active)
    );

    // State register and quadlet holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            hdr_q <= '0;
            chk_q <= '0;
        end else begin
            state <= state_n;
            if (rx_valid && state != ST_WAIT_CHECK) begin
                hdr_q <= rx_data;
            end
            if (rx_valid && state == ST_WAIT_CHECK) begin
                chk_q <= rx_data;
            end
        end
    end

    // Next-state logic; a bus reset overrides every state
    always_comb begin
        state_n = state;
        if (bus_reset) begin
            state_n = ctrl_q[CB_BR_WORD] ? ST_BR_EMIT : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:       state_n = rx_valid ? ST_WAIT_CHECK : ST_IDLE;
                ST_WAIT_CHECK: state_n = rx_valid ? ST_ACT : ST_WAIT_CHECK;
                ST_ACT:        state_n = rx_valid ? ST_WAIT_CHECK : ST_IDLE;
                ST_BR_EMIT:    state_n = rx_valid ? ST_WAIT_CHECK : ST_IDLE;
            endcase
        end
    end

    // Output logic
    always_comb begin
        act_cycle = (state == ST_ACT) && !bus_reset;
        pass      = !ctrl_q[CB_CHECK] || (chk_q == ~hdr_q);
        fire      = act_cycle && pass;

        out_valid = 1'b0;
        out_is_br = 1'b0;
        out_data  = '0;
        unique case (state)
            ST_IDLE, ST_WAIT_CHECK: begin
                out_valid = 1'b0;
            end
            ST_ACT: begin
                out_valid = fire;
                out_data  = fire ? hdr_q : '0;
            end
            ST_BR_EMIT: begin
                out_valid = 1'b1;
                out_is_br = 1'b1;
                out_data  = BR_WORD;
            end
        endcase

        req_self_id        = fire && (cls == PK_PING)     && ctrl_q[CB_AUTO_PING];
        req_remote_reply   = fire && (cls == PK_RACCESS)  && ctrl_q[CB_AUTO_RMT];
        req_remote_confirm = fire && (cls == PK_RCOMMAND) && ctrl_q[CB_AUTO_RMT];

        upd_gap  = fire && (cls == PK_CONFIG) && ctrl_q[CB_AUTO_CFG] && cfg_t;
        upd_rhb  = fire && (cls == PK_CONFIG) && ctrl_q[CB_AUTO_CFG] && cfg_r;
        set_link = fire && (cls == PK_LINKON);

        link_ok  = host_link_en && (!ctrl_q[CB_LINK_GATE] || link_active);
    end

endmodule

// File: rtl/phy_rx_ctrl_chk.sv
module phy_rx_ctrl_chk #(
    parameter int QW   = 32,
    parameter int GAPW = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [5:0]      ctrl_q,
    input logic            host_link_en,
    input logic            bus_reset,
    input logic            rx_valid,
    input logic            out_valid,
    input logic            out_is_br,
    input logic [GAPW-1:0] gap_count,
    input logic            link_active,
    input logic            link_ok,
    input logic            req_self_id,
    input logic            req_remote_reply,
    input logic            req_remote_confirm
);

    p_req_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_self_id, req_remote_reply, req_remote_confirm}));

    p_req_with_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_self_id || req_remote_reply || req_remote_confirm) |-> (out_valid && !out_is_br));

    p_selfid_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_self_id |-> ctrl_q[2]);

    p_remote_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_remote_reply || req_remote_confirm) |-> ctrl_q[3]);

    p_gap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[0] |=> $stable(gap_count));

    p_link_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_ok |-> (host_link_en && (!ctrl_q[1] || link_active)));

    p_link_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !link_active);

    p_no_req_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |-> !(req_self_id || req_remote_reply || req_remote_confirm));

    p_br_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && ctrl_q[4]) |=> (out_valid && out_is_br));

    p_fwd_after_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_br) |-> $past(rx_valid));

endmodule

bind phy_rx_ctrl phy_rx_ctrl_chk #(
    .QW   (QW),
    .GAPW (GAPW)
) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .ctrl_q             (ctrl_q),
    .host_link_en       (host_link_en),
    .bus_reset          (bus_reset),
    .rx_valid           (rx_valid),
    .out_valid          (out_valid),
    .out_is_br          (out_is_br),
    .gap_count          (gap_count),
    .link_active        (link_active),
    .link_ok            (link_ok),
    .req_self_id        (req_self_id),
    .req_remote_reply   (req_remote_reply),
    .req_remote_confirm (req_remote_confirm)
);

// File: tb/phy_rx_ctrl_test.sv
`timescale 1ns/1ps
module phy_rx_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_wdata = '0;
    logic [5:0]  ctrl_q;
    logic [5:0]  node_id = 6'd5;
    logic        host_link_en = 1'b0;
    logic        bus_reset = 1'b0;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_data = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_is_br;
    logic [5:0]  gap_count;
    logic        rhb, link_active, link_ok;
    logic        req_self_id, req_remote_reply, req_remote_confirm;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    phy_rx_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ctrl_q(ctrl_q), .node_id(node_id), .host_link_en(host_link_en),
        .bus_reset(bus_reset), .rx_valid(rx_valid), .rx_data(rx_data),
        .out_valid(out_valid), .out_data(out_data), .out_is_br(out_is_br),
        .gap_count(gap_count), .rhb(rhb), .link_active(link_active),
        .link_ok(link_ok), .req_self_id(req_self_id),
        .req_remote_reply(req_remote_reply), .req_remote_confirm(req_remote_confirm)
    );

    // {ctrl, header, check quadlet, expected {fwd, self_id, reply, confirm}}
    localparam int NV = 11;
    localparam logic [73:0] VEC [NV] = '{
        {6'b011100, 32'h0500_0000, 32'h0000_0000, 4'b1100},  // R5 ping to self
        {6'b011100, 32'h0700_0000, 32'h0000_0000, 4'b1000},  // R5 ping to other node
        {6'b011000, 32'h0500_0000, 32'h0000_0000, 4'b1000},  // R5 auto-ping off
        {6'b011100, 32'h0504_0000, 32'h0000_0000, 4'b1010},  // R6 remote access
        {6'b011100, 32'h0520_0000, 32'h0000_0000, 4'b1001},  // R6 remote command
        {6'b010100, 32'h0504_0000, 32'h0000_0000, 4'b1000},  // R6 auto-remote off
        {6'b111100, 32'h0500_0000, 32'hFAFF_FFFF, 4'b1100},  // R2 good inverse
        {6'b111100, 32'h0500_0000, 32'h0000_0000, 4'b0000},  // R2 bad inverse
        {6'b111100, 32'h0504_0000, 32'h1234_5678, 4'b0000},  // R2 bad inverse remote
        {6'b011100, 32'h8000_0000, 32'h0000_0000, 4'b1000},  // R9 self-ID header
        {6'b011100, 32'h0508_0000, 32'h0000_0000, 4'b1000}   // R9 other sub-type
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [5:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Returns just after the falling edge of the action cycle
    task automatic send(input logic [31:0] q0, input logic [31:0] q1);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data = q0;
        @(negedge clk);
        rx_data = q1;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_data = '0;
        #1;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 ctrl_q", 32'(ctrl_q), 32'h1C);
        chk("R1 gap_count", 32'(gap_count), 32'h3F);
        chk("R1 rhb", 32'(rhb), 0);
        chk("R1 link_active", 32'(link_active), 0);
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 reqs", 32'({req_self_id, req_remote_reply, req_remote_confirm}), 0);

        // R10 control write
        write_ctrl(6'b101010);
        #1;
        chk("R10 ctrl write", 32'(ctrl_q), 32'h2A);

        // Vector table: R2 R3 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            write_ctrl(VEC[i][73:68]);
            send(VEC[i][67:36], VEC[i][35:4]);
            chk($sformatf("R3 vec%0d out_valid", i), 32'(out_valid), 32'(VEC[i][3]));
            chk($sformatf("R5 vec%0d req_self_id", i), 32'(req_self_id), 32'(VEC[i][2]));
            chk($sformatf("R6 vec%0d req_remote_reply", i), 32'(req_remote_reply), 32'(VEC[i][1]));
            chk($sformatf("R6 vec%0d req_remote_confirm", i), 32'(req_remote_confirm), 32'(VEC[i][0]));
            if (VEC[i][3]) chk($sformatf("R3 vec%0d out_data", i), out_data, VEC[i][67:36]);
            @(negedge clk);
            #1;
            chk($sformatf("R3 vec%0d single pulse", i), 32'(out_valid), 0);
        end
        chk("R9 gap untouched", 32'(gap_count), 32'h3F);
        chk("R9 link untouched", 32'(link_active), 0);

        // R4 configuration packets
        write_ctrl(6'b011101);
        send(32'h05EA_0000, 32'h0);
        @(negedge clk); #1;
        chk("R4 gap load", 32'(gap_count), 32'h2A);
        chk("R4 rhb root match", 32'(rhb), 1);
        send(32'h0980_0000, 32'h0);
        @(negedge clk); #1;
        chk("R4 rhb root mismatch", 32'(rhb), 0);
        chk("R4 gap kept when T clear", 32'(gap_count), 32'h2A);
        write_ctrl(6'b011100);
        send(32'h0950_0000, 32'h0);
        chk("R4 cfg forwarded", 32'(out_valid), 1);
        @(negedge clk); #1;
        chk("R4 gap kept when disabled", 32'(gap_count), 32'h2A);
        write_ctrl(6'b011101);
        send(32'h0950_0000, 32'h0);
        @(negedge clk); #1;
        chk("R4 gap reload", 32'(gap_count), 32'h10);

        // R7 link gating
        host_link_en = 1'b1;
        write_ctrl(6'b011110);
        #1;
        chk("R7 gated before link-on", 32'(link_ok), 0);
        send(32'h4600_0000, 32'h0);
        @(negedge clk); #1;
        chk("R7 link-on other node", 32'(link_active), 0);
        send(32'h4500_0000, 32'h0);
        @(negedge clk); #1;
        chk("R7 link-on sets flag", 32'(link_active), 1);
        chk("R7 link_ok open", 32'(link_ok), 1);
        host_link_en = 1'b0;
        #1;
        chk("R7 host disable", 32'(link_ok), 0);
        host_link_en = 1'b1;

        // R8 bus reset with word enabled
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
        #1;
        chk("R8 br out_valid", 32'(out_valid), 1);
        chk("R8 br flag", 32'(out_is_br), 1);
        chk("R8 br word", out_data, 32'hE000_0000);
        chk("R8 link cleared", 32'(link_active), 0);
        chk("R7 gated after reset", 32'(link_ok), 0);
        write_ctrl(6'b011100);
        #1;
        chk("R7 ungated mode", 32'(link_ok), 1);

        // R8 bus reset during action cycle suppresses request
        send(32'h0500_0000, 32'h0);
        bus_reset = 1'b1;
        #1;
        chk("R8 fwd suppressed", 32'(out_valid), 0);
        chk("R8 req suppressed", 32'(req_self_id), 0);
        @(negedge clk);
        bus_reset = 1'b0;
        #1;
        chk("R8 br after suppress", 32'(out_is_br), 1);

        // R8 bus reset mid-packet, word disabled
        write_ctrl(6'b001100);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data = 32'h4600_0000;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_data = '0;
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
        #1;
        chk("R8 no br word when off", 32'(out_valid), 0);
        send(32'h0500_0000, 32'h0);
        chk("R8 abort then fwd", out_data, 32'h0500_0000);
        chk("R8 abort then self-id", 32'(req_self_id), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule